// File: doc/BRIEF.md
# Command-Buffer SPI Master

This block is an SPI master that takes each job from a shared byte buffer rather than from a set of control registers. Software fills the buffer through a byte write port. The first two bytes form a 16-bit little-endian header that names the operation and the byte count, and any transmit bytes follow at offset 2. Software then writes a command word. The command word starts the job immediately, or arms it to wait for an external trigger. The same word can also halt a running job, or flush it. The command word also picks a timing profile, which the block passes on to the clock generator, and one slave-select line.

The engine shifts bytes MSB first. In single-line mode it drives line 0 and samples line 1. In two-line mode it moves two bits per clock on both lines. Received bytes are stored from buffer offset 0. When the last byte is complete, the engine releases slave select and pulses done for one cycle. A malformed header pulses an invalid flag instead. So does a start that arrives while a job is pending.

The buffer write port is valid/ready. A byte is accepted only on a cycle where both are high. Ready is high only while the engine is idle: no job is armed and none is running. A byte offered while ready is low is not stored and must be held until ready returns. The buffer read port and the command and trigger inputs are plain signals with no back-pressure.

Top module: `spi_cb_engine`

## Requirements
- R1: After reset all slave selects are high, sclk is low, done and invalid are low, the write port is ready, line enables are 01 and line 0 sits at the idle level (default 1).
- R2: Buffer writes are taken only while the engine is idle. A write offered during a job leaves the buffer unchanged.
- R3: The header is byte 0 (low) and byte 1 (high). Bits 15:13 are the opcode: 0 sleep, 1 read-write, 2 write, 3 read, 4 set-interrupt. Bit 11 is the two-line flag. Bits 10:0 are the byte count.
- R4: In a single-line write, byte k comes from offset 2+k and goes out MSB first on line 0, one bit per rising sclk edge, with sclk low at idle. The select chosen by command bits 12 upward is low (active) for the whole job and is the only one low.
- R5: In read-write, line 1 is sampled at each rising sclk edge while transmitting, and received byte k is stored at offset k.
- R6: In read-only, line 0 is held at the idle level. Counts up to the full buffer size (512) are accepted.
- R7: In two-line mode, each clock carries two bits, with line 1 holding the higher one. A write drives both lines (enables 11). A read drives neither (enables 00).
- R8: After the last byte, done is high for exactly one cycle, and all selects are high by then.
- R9: Sleep pulses done no earlier than count cycles after the start. Set-interrupt, and any transfer with count 0, pulse done without any sclk edge.
- R10: A header with opcode 5 to 7, with the two-line flag on anything but read or write, or with a count over 510 (write or read-write) or over 512 (read) gives one invalid pulse, no done and no sclk edge.
- R11: A start command (code 1 or 2) while a job is armed or running gives an invalid pulse and has no effect on that job.
- R12: Code 2 arms the job. No select or clock activity happens until a trigger pulse arrives.
- R13: Code 3 (halt) aborts at once with no done pulse, selects high and sclk low. Code 4 (flush) also aborts and sets header bytes 0 and 1 to zero.
- R14: The profile output shows command bits 11:8 as captured at the accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| buf_wr_valid | input | 1 | Buffer write offered |
| buf_wr_ready | output | 1 | Buffer write accepted (engine idle) |
| buf_wr_addr | input | 9 | Buffer write byte offset |
| buf_wr_data | input | 8 | Buffer write byte |
| buf_rd_addr | input | 9 | Buffer read byte offset |
| buf_rd_data | output | 8 | Buffer read byte (combinational) |
| cmd_valid | input | 1 | Command word strobe |
| cmd_word | input | 15 | Code [3:0], profile [11:8], select [14:12] |
| trig_i | input | 1 | External start trigger |
| sclk_o | output | 1 | Serial clock |
| ss_n_o | output | 8 | Active-low slave selects |
| sd_o | output | 2 | Data line outputs |
| sd_oe_o | output | 2 | Data line output enables |
| sd_i | input | 2 | Data line inputs |
| prof_o | output | 4 | Captured timing profile |
| done_o | output | 1 | Job complete pulse |
| invalid_o | output | 1 | Rejected header or command pulse |

## Verification
Each stimulus pattern targets one kind of fault. The transfer path runs as a single-line write, a read-write on a different select, a single-line read, a two-line write and a two-line read, each with its own byte pattern. Comparing the bytes shifted out with the bytes stored back separates faults in line choice, bit order and offset handling. A read of the full 512 bytes, and counts just beyond each limit, probe the count boundaries. Sleep, set-interrupt, zero count, halt, flush, armed trigger, a second start during a job and buffer writes during a job each show whether done, invalid and the buffer behave as stated for that control case.

// File: rtl/spi_cb_pkg.sv
package spi_cb_pkg;
  // header field positions
  localparam int HDR_CNT_W  = 11;
  localparam int HDR_MB_BIT = 11;
  localparam int HDR_OP_LSB = 13;

  // command word field positions
  localparam int CMD_CODE_W   = 4;
  localparam int CMD_PROF_LSB = 8;
  localparam int PROF_W       = 4;
  localparam int CMD_SS_LSB   = 12;

  localparam logic [2:0] OP_SLEEP = 3'd0;
  localparam logic [2:0] OP_XFER  = 3'd1;
  localparam logic [2:0] OP_WR    = 3'd2;
  localparam logic [2:0] OP_RD    = 3'd3;
  localparam logic [2:0] OP_IRQ   = 3'd4;

  localparam logic [3:0] CMD_NOP     = 4'd0;
  localparam logic [3:0] CMD_GO      = 4'd1;
  localparam logic [3:0] CMD_GO_TRIG = 4'd2;
  localparam logic [3:0] CMD_HALT    = 4'd3;
  localparam logic [3:0] CMD_FLUSH   = 4'd4;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ARMED, ST_HDR, ST_SLEEP, ST_LOAD, ST_SHIFT
  } eng_st_e;
endpackage

// File: rtl/spi_cb_buffer.sv
module spi_cb_buffer #(
  parameter int BUF_BYTES = 512,
  localparam int AW = $clog2(BUF_BYTES)
) (
  input  logic          clk,
  input  logic          host_we,
  input  logic [AW-1:0] host_addr,
  input  logic [7:0]    host_data,
  input  logic          eng_we,
  input  logic [AW-1:0] eng_addr,
  input  logic [7:0]    eng_data,
  input  logic          clr_hdr,
  input  logic [AW-1:0] rd_addr,
  output logic [7:0]    rd_data,
  input  logic [AW-1:0] tx_addr,
  output logic [7:0]    tx_data,
  output logic [15:0]   hdr_word
);
  logic [7:0] mem [BUF_BYTES];

  always_ff @(posedge clk) begin
    if (host_we) mem[host_addr] <= host_data;
    if (eng_we)  mem[eng_addr]  <= eng_data;
    if (clr_hdr) begin
      mem[0] <= 8'h00;
      mem[1] <= 8'h00;
    end
  end

  assign rd_data  = mem[rd_addr];
  assign tx_data  = mem[tx_addr];
  assign hdr_word = {mem[1], mem[0]};

  // host and engine never write in the same cycle: host only while idle
  p_one_writer_r2: assert property (@(posedge clk) !(host_we && eng_we))
    else $error("buffer written by host and engine together");
endmodule

// File: rtl/spi_cb_decode.sv
module spi_cb_decode
  import spi_cb_pkg::*;
#(
  parameter int BUF_BYTES = 512
) (
  input  logic [15:0]          hdr_word,
  output logic [2:0]           op,
  output logic                 multi,
  output logic [HDR_CNT_W-1:0] cnt,
  output logic                 ok,
  output logic                 rx_op,
  output logic                 tx_op
);
  localparam logic [HDR_CNT_W-1:0] LIM_RD = HDR_CNT_W'(BUF_BYTES);
  localparam logic [HDR_CNT_W-1:0] LIM_TX = HDR_CNT_W'(BUF_BYTES - 2);

  logic unused_hdr_bit;
  logic op_known, multi_ok, cnt_ok;

  assign op             = hdr_word[HDR_OP_LSB +: 3];
  assign multi          = hdr_word[HDR_MB_BIT];
  assign cnt            = hdr_word[HDR_CNT_W-1:0];
  assign unused_hdr_bit = hdr_word[12];

  assign rx_op = (op == OP_XFER) || (op == OP_RD);
  assign tx_op = (op == OP_XFER) || (op == OP_WR);

  always_comb begin
    op_known = (op <= OP_IRQ);
    multi_ok = !multi || (op == OP_WR) || (op == OP_RD);
    unique case (op)
      OP_RD:        cnt_ok = (cnt <= LIM_RD);
      OP_WR, OP_XFER: cnt_ok = (cnt <= LIM_TX);
      default:      cnt_ok = 1'b1;
    endcase
    ok = op_known && multi_ok && cnt_ok;
  end
endmodule

// File: rtl/spi_cb_shifter.sv
module spi_cb_shifter #(
  parameter int   HALF_CYC = 2,
  parameter logic IDLE_LVL = 1'b1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       abort,
  input  logic       start,
  input  logic [7:0] tx_byte,
  input  logic       tx_en,
  input  logic       dual,
  input  logic [1:0] sd_i,
  output logic       sclk,
  output logic [1:0] sd_o,
  output logic       busy,
  output logic       byte_done,
  output logic [7:0] rx_byte
);
  localparam int HW = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;
  localparam logic [HW-1:0] H_LAST = HW'(HALF_CYC - 1);

  logic [7:0]    sh, rx;
  logic [3:0]    left;
  logic [HW-1:0] hcnt;
  logic          txen_r, dual_r;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh <= '0; rx <= '0; left <= '0; hcnt <= '0;
      txen_r <= 1'b0; dual_r <= 1'b0;
      sclk <= 1'b0; busy <= 1'b0; byte_done <= 1'b0;
    end else begin
      byte_done <= 1'b0;
      if (abort) begin
        busy <= 1'b0;
        sclk <= 1'b0;
        hcnt <= '0;
      end else if (start) begin
        busy   <= 1'b1;
        sh     <= tx_byte;
        txen_r <= tx_en;
        dual_r <= dual;
        left   <= dual ? 4'd4 : 4'd8;
        hcnt   <= '0;
        sclk   <= 1'b0;
      end else if (busy) begin
        if (hcnt == H_LAST) begin
          hcnt <= '0;
          if (!sclk) begin
            sclk <= 1'b1;
            rx   <= dual_r ? {rx[5:0], sd_i} : {rx[6:0], sd_i[1]};
          end else begin
            sclk <= 1'b0;
            if (left == 4'd1) begin
              busy      <= 1'b0;
              byte_done <= 1'b1;
            end else begin
              sh   <= dual_r ? {sh[5:0], 2'b00} : {sh[6:0], 1'b0};
              left <= left - 4'd1;
            end
          end
        end else begin
          hcnt <= hcnt + HW'(1);
        end
      end
    end
  end

  always_comb begin
    sd_o[0] = IDLE_LVL;
    sd_o[1] = 1'b0;
    if (busy && txen_r) begin
      sd_o[0] = dual_r ? sh[6] : sh[7];
      sd_o[1] = dual_r & sh[7];
    end
  end

  assign rx_byte = rx;

  p_start_when_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !busy) else $error("byte started while shifter busy");
  p_sclk_low_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    byte_done |-> !sclk) else $error("sclk high at byte end");
endmodule

// File: rtl/spi_cb_engine.sv
module spi_cb_engine
  import spi_cb_pkg::*;
#(
  parameter int   BUF_BYTES = 512,
  parameter int   SS_W      = 3,
  parameter int   HALF_CYC  = 2,
  parameter logic IDLE_LVL  = 1'b1,
  localparam int  AW        = $clog2(BUF_BYTES),
  localparam int  NUM_SS    = 1 << SS_W,
  localparam int  CMD_W     = CMD_SS_LSB + SS_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              buf_wr_valid,
  output logic              buf_wr_ready,
  input  logic [AW-1:0]     buf_wr_addr,
  input  logic [7:0]        buf_wr_data,
  input  logic [AW-1:0]     buf_rd_addr,
  output logic [7:0]        buf_rd_data,
  input  logic              cmd_valid,
  input  logic [CMD_W-1:0]  cmd_word,
  input  logic              trig_i,
  output logic              sclk_o,
  output logic [NUM_SS-1:0] ss_n_o,
  output logic [1:0]        sd_o,
  output logic [1:0]        sd_oe_o,
  input  logic [1:0]        sd_i,
  output logic [PROF_W-1:0] prof_o,
  output logic              done_o,
  output logic              invalid_o
);
  localparam int CNT_W = HDR_CNT_W;

  eng_st_e              st;
  logic [SS_W-1:0]      ss_sel;
  logic [PROF_W-1:0]    prof;
  logic [2:0]           op_r;
  logic                 multi_r;
  logic [CNT_W-1:0]     total, idx;
  logic                 done_q, inv_q;

  logic [CMD_CODE_W-1:0] code;
  logic [3:0]            unused_cmd_bits;
  logic                  abort, host_we, eng_we, sh_start, active;
  logic [15:0]           hdr_word;
  logic [2:0]            h_op;
  logic                  h_multi, h_ok, h_rx, h_tx, unused_h_tx;
  logic [CNT_W-1:0]      h_cnt;
  logic [7:0]            tx_data, rx_byte;
  logic                  busy, byte_done, rx_now;

  assign code            = cmd_word[CMD_CODE_W-1:0];
  assign unused_cmd_bits = cmd_word[7:4];
  assign abort    = cmd_valid && ((code == CMD_HALT) || (code == CMD_FLUSH));
  assign buf_wr_ready = (st == ST_IDLE);
  assign host_we  = buf_wr_valid && buf_wr_ready;
  assign rx_now   = (op_r == OP_XFER) || (op_r == OP_RD);
  assign eng_we   = (st == ST_SHIFT) && byte_done && rx_now;
  assign sh_start = (st == ST_LOAD) && !abort;
  assign active   = (st == ST_LOAD) || (st == ST_SHIFT);
  assign unused_h_tx = h_tx ^ h_rx;

  spi_cb_buffer #(.BUF_BYTES(BUF_BYTES)) u_buf (
    .clk       (clk),
    .host_we   (host_we),
    .host_addr (buf_wr_addr),
    .host_data (buf_wr_data),
    .eng_we    (eng_we),
    .eng_addr  (AW'(idx)),
    .eng_data  (rx_byte),
    .clr_hdr   (cmd_valid && (code == CMD_FLUSH)),
    .rd_addr   (buf_rd_addr),
    .rd_data   (buf_rd_data),
    .tx_addr   (AW'(idx + CNT_W'(2))),
    .tx_data   (tx_data),
    .hdr_word  (hdr_word)
  );

  spi_cb_decode #(.BUF_BYTES(BUF_BYTES)) u_dec (
    .hdr_word (hdr_word),
    .op       (h_op),
    .multi    (h_multi),
    .cnt      (h_cnt),
    .ok       (h_ok),
    .rx_op    (h_rx),
    .tx_op    (h_tx)
  );

  spi_cb_shifter #(.HALF_CYC(HALF_CYC), .IDLE_LVL(IDLE_LVL)) u_shf (
    .clk       (clk),
    .rst_n     (rst_n),
    .abort     (abort),
    .start     (sh_start),
    .tx_byte   (tx_data),
    .tx_en     ((op_r == OP_XFER) || (op_r == OP_WR)),
    .dual      (multi_r),
    .sd_i      (sd_i),
    .sclk      (sclk_o),
    .sd_o      (sd_o),
    .busy      (busy),
    .byte_done (byte_done),
    .rx_byte   (rx_byte)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_IDLE; ss_sel <= '0; prof <= '0; op_r <= OP_SLEEP;
      multi_r <= 1'b0; total <= '0; idx <= '0; done_q <= 1'b0; inv_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      inv_q  <= 1'b0;
      case (st)
        ST_ARMED: if (trig_i) st <= ST_HDR;
        ST_HDR: begin
          if (!h_ok) begin
            inv_q <= 1'b1;
            st    <= ST_IDLE;
          end else begin
            op_r    <= h_op;
            multi_r <= h_multi;
            total   <= h_cnt;
            idx     <= '0;
            if ((h_op == OP_IRQ) || (h_cnt == '0)) begin
              done_q <= 1'b1;
              st     <= ST_IDLE;
            end else if (h_op == OP_SLEEP) begin
              idx <= CNT_W'(1);
              st  <= ST_SLEEP;
            end else begin
              st <= ST_LOAD;
            end
          end
        end
        ST_SLEEP: begin
          if (idx == total) begin
            done_q <= 1'b1;
            st     <= ST_IDLE;
          end else begin
            idx <= idx + CNT_W'(1);
          end
        end
        ST_LOAD: st <= ST_SHIFT;
        ST_SHIFT: begin
          if (byte_done) begin
            if (idx == total - CNT_W'(1)) begin
              done_q <= 1'b1;
              st     <= ST_IDLE;
            end else begin
              idx <= idx + CNT_W'(1);
              st  <= ST_LOAD;
            end
          end
        end
        default: ;
      endcase
      if (cmd_valid) begin
        case (code)
          CMD_GO, CMD_GO_TRIG: begin
            if (st == ST_IDLE) begin
              ss_sel <= cmd_word[CMD_SS_LSB +: SS_W];
              prof   <= cmd_word[CMD_PROF_LSB +: PROF_W];
              st     <= (code == CMD_GO) ? ST_HDR : ST_ARMED;
            end else begin
              inv_q <= 1'b1;
            end
          end
          CMD_HALT, CMD_FLUSH: begin
            st     <= ST_IDLE;
            done_q <= 1'b0;
          end
          default: ;
        endcase
      end
    end
  end

  assign ss_n_o    = active ? ~(NUM_SS'(1) << ss_sel) : '1;
  assign sd_oe_o   = !active ? 2'b01 :
                     !multi_r ? 2'b01 :
                     (op_r == OP_RD) ? 2'b00 : 2'b11;
  assign prof_o    = prof;
  assign done_o    = done_q;
  assign invalid_o = inv_q;

  p_ss_onehot_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~ss_n_o)) else $error("more than one select low");
  p_sclk_needs_ss_r4: assert property (@(posedge clk) disable iff (!rst_n)
    sclk_o |-> !(&ss_n_o)) else $error("sclk toggles without select");
  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o) else $error("done longer than one cycle");
  p_done_ss_released_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (&ss_n_o)) else $error("select still low at done");
  p_ready_only_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    buf_wr_ready |-> (&ss_n_o && !busy)) else $error("ready during job");
  p_no_done_on_invalid_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(invalid_o) |-> !done_o) else $error("invalid with done");
endmodule

// File: tb/test_spi_cb_engine.sv
`timescale 1ns/1ps
module test_spi_cb_engine;
  localparam int BUF = 512;
  localparam int NSS = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        buf_wr_valid = 1'b0;
  logic        buf_wr_ready;
  logic [8:0]  buf_wr_addr = '0;
  logic [7:0]  buf_wr_data = '0;
  logic [8:0]  buf_rd_addr = '0;
  logic [7:0]  buf_rd_data;
  logic        cmd_valid = 1'b0;
  logic [14:0] cmd_word = '0;
  logic        trig_i = 1'b0;
  logic        sclk_o;
  logic [NSS-1:0] ss_n_o;
  logic [1:0]  sd_o, sd_oe_o;
  logic [1:0]  sd_i = 2'b00;
  logic [3:0]  prof_o;
  logic        done_o, invalid_o;

  always #2 clk = ~clk;

  spi_cb_engine i_spi_cb_engine (
    .clk(clk), .rst_n(rst_n),
    .buf_wr_valid(buf_wr_valid), .buf_wr_ready(buf_wr_ready),
    .buf_wr_addr(buf_wr_addr), .buf_wr_data(buf_wr_data),
    .buf_rd_addr(buf_rd_addr), .buf_rd_data(buf_rd_data),
    .cmd_valid(cmd_valid), .cmd_word(cmd_word), .trig_i(trig_i),
    .sclk_o(sclk_o), .ss_n_o(ss_n_o), .sd_o(sd_o), .sd_oe_o(sd_oe_o),
    .sd_i(sd_i), .prof_o(prof_o), .done_o(done_o), .invalid_o(invalid_o)
  );

  int n_cmp = 0, n_bad = 0;
  int done_hi = 0, inv_hi = 0, n_rise = 0;
  logic mon_on = 1'b0, mon_dual = 1'b0;
  logic [NSS-1:0] exp_ssn = '1;
  logic [1:0] exp_oe = 2'b01;
  logic [7:0] sbytes [BUF];
  int sbi = 0;
  logic [7:0] got [$];
  logic [7:0] cap = '0;
  int capn = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // event counters and serial slave model
  always @(posedge clk) if (rst_n) begin
    if (done_o) done_hi++;
    if (invalid_o) inv_hi++;
  end

  always @(posedge sclk_o) begin
    n_rise++;
    if (mon_dual) begin cap = {cap[5:0], sd_o[1], sd_o[0]}; capn += 2; end
    else begin cap = {cap[6:0], sd_o[0]}; capn += 1; end
    if (capn == 8) begin got.push_back(cap); capn = 0; end
  end

  function automatic logic sbit(input int i);
    return sbytes[(i / 8) % BUF][7 - (i % 8)];
  endfunction

  task automatic drive_sd();
    sd_i = mon_dual ? {sbit(sbi), sbit(sbi + 1)} : {sbit(sbi), 1'b0};
  endtask

  always @(negedge sclk_o) begin
    sbi += mon_dual ? 2 : 1;
    drive_sd();
  end

  // per-clock comparison against the expected select and enable pattern
  always @(negedge clk) if (mon_on) begin
    if (sclk_o) chk(ss_n_o == exp_ssn, "R4", "select during sclk", ss_n_o, exp_ssn);
    chk(sd_oe_o == ((&ss_n_o) ? 2'b01 : exp_oe), "R7", "line enables",
        sd_oe_o, (&ss_n_o) ? 2'b01 : exp_oe);
  end

  task automatic host_wr(input int a, input logic [7:0] d);
    @(negedge clk);
    buf_wr_valid = 1'b1; buf_wr_addr = 9'(a); buf_wr_data = d;
    @(negedge clk);
    buf_wr_valid = 1'b0;
  endtask

  task automatic rd(input int a, output logic [7:0] d);
    @(negedge clk);
    buf_rd_addr = 9'(a);
    #1 d = buf_rd_data;
  endtask

  task automatic set_hdr(input int op, input bit mb, input int cnt);
    logic [15:0] w;
    w = {3'(op), 1'b0, mb, 11'(cnt)};
    host_wr(0, w[7:0]);
    host_wr(1, w[15:8]);
  endtask

  task automatic cmd(input int code, input int prof, input int ss);
    @(negedge clk);
    cmd_valid = 1'b1;
    cmd_word  = {3'(ss), 4'(prof), 4'b0, 4'(code)};
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic prep(input bit dual, input int ss, input logic [1:0] oe, input int seed);
    got.delete(); capn = 0; cap = '0; sbi = 0;
    mon_dual = dual; exp_ssn = ~(NSS'(1) << ss); exp_oe = oe;
    for (int i = 0; i < BUF; i++) sbytes[i] = 8'(i * 29 + seed);
    drive_sd();
  endtask

  task automatic wait_done(input int maxc, output int cyc);
    int d0;
    d0 = done_hi; cyc = 0;
    while (done_hi == d0 && cyc < maxc) begin @(negedge clk); cyc++; end
  endtask

  function automatic logic [7:0] txb(input int k, input int seed);
    return 8'(k * 13 + seed);
  endfunction

  // full transfer with checks of serial data, stored data, done and profile
  task automatic run_xfer(input int op, input bit mb, input int cnt, input int ss,
                          input int prof, input int seed, input string req);
    int d0, r0, cyc;
    logic [7:0] v;
    logic [1:0] oe;
    bit tx, rx;
    tx = (op == 1) || (op == 2);
    rx = (op == 1) || (op == 3);
    oe = !mb ? 2'b01 : (op == 3) ? 2'b00 : 2'b11;
    if (tx) for (int k = 0; k < cnt; k++) host_wr(2 + k, txb(k, seed));
    set_hdr(op, mb, cnt);
    prep(mb, ss, oe, seed);
    d0 = done_hi; r0 = n_rise;
    cmd(1, prof, ss);
    wait_done(cnt * 40 + 100, cyc);
    chk(&ss_n_o, "R8", "select released at done", ss_n_o, '1);
    repeat (4) @(negedge clk);
    chk(done_hi - d0 == 1, "R8", "single done pulse", done_hi - d0, 1);
    chk(n_rise - r0 == (mb ? 4 : 8) * cnt, req, "sclk edges", n_rise - r0, (mb ? 4 : 8) * cnt);
    chk(prof_o == 4'(prof), "R14", "profile", prof_o, prof);
    if (!(mb && op == 3)) begin
      chk(got.size() == cnt, req, "bytes shifted", got.size(), cnt);
      for (int k = 0; k < cnt && k < got.size(); k++)
        chk(got[k] == (tx ? txb(k, seed) : 8'hFF), tx ? req : "R6",
            "serial byte", got[k], tx ? txb(k, seed) : 8'hFF);
    end
    if (rx) for (int k = 0; k < cnt; k += (cnt > 8 ? 61 : 1)) begin
      rd(k, v);
      chk(v == sbytes[k], req, "stored byte", v, sbytes[k]);
    end
  endtask

  task automatic expect_invalid(input int op, input bit mb, input int cnt);
    int d0, i0, r0;
    set_hdr(op, mb, cnt);
    d0 = done_hi; i0 = inv_hi; r0 = n_rise;
    cmd(1, 0, 0);
    repeat (20) @(negedge clk);
    chk(inv_hi - i0 == 1, "R10", "invalid pulse", inv_hi - i0, 1);
    chk(done_hi == d0, "R10", "no done", done_hi - d0, 0);
    chk(n_rise == r0, "R10", "no sclk", n_rise - r0, 0);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin : main
    int d0, i0, r0, cyc;
    logic [7:0] v;
    prep(1'b0, 0, 2'b01, 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(&ss_n_o, "R1", "selects", ss_n_o, '1);
    chk(!sclk_o, "R1", "sclk", sclk_o, 0);
    chk(!done_o && !invalid_o, "R1", "pulses", {done_o, invalid_o}, 0);
    chk(buf_wr_ready, "R1", "ready", buf_wr_ready, 1);
    chk(sd_oe_o == 2'b01 && sd_o[0], "R1", "line idle", {sd_oe_o, sd_o}, 5'b0101);
    mon_on = 1'b1;

    // R3 R4 single write, R5 read-write, R6 read-only, R7 two-line
    run_xfer(2, 1'b0, 3, 2, 5, 7, "R4");
    run_xfer(1, 1'b0, 4, 0, 9, 3, "R5");
    run_xfer(3, 1'b0, 2, 6, 2, 11, "R6");
    run_xfer(2, 1'b1, 3, 1, 12, 21, "R7");
    run_xfer(3, 1'b1, 2, 7, 3, 40, "R7");

    // R9 sleep, set-interrupt, zero count
    set_hdr(0, 1'b0, 20);
    r0 = n_rise;
    cmd(1, 0, 0);
    wait_done(200, cyc);
    chk(cyc >= 20 && cyc < 200, "R9", "sleep length", cyc, 20);
    chk(n_rise == r0, "R9", "sleep no sclk", n_rise - r0, 0);
    set_hdr(4, 1'b0, 0);
    cmd(1, 0, 0);
    wait_done(20, cyc);
    chk(cyc < 20 && n_rise == r0, "R9", "set-interrupt done", cyc, 2);
    set_hdr(2, 1'b0, 0);
    cmd(1, 0, 0);
    wait_done(20, cyc);
    chk(cyc < 20 && n_rise == r0, "R9", "zero count done", cyc, 2);

    // R10 malformed headers
    expect_invalid(6, 1'b0, 3);
    expect_invalid(1, 1'b1, 3);
    expect_invalid(2, 1'b0, 511);
    expect_invalid(3, 1'b0, 513);

    // R11 second start and R2 write during a job
    host_wr(100, 8'h11);
    for (int k = 0; k < 4; k++) host_wr(2 + k, txb(k, 50));
    set_hdr(2, 1'b0, 4);
    prep(1'b0, 3, 2'b01, 50);
    d0 = done_hi; i0 = inv_hi;
    cmd(1, 1, 3);
    repeat (10) @(negedge clk);
    cmd(1, 6, 5);
    @(negedge clk);
    chk(!buf_wr_ready, "R2", "ready low while busy", buf_wr_ready, 0);
    buf_wr_valid = 1'b1; buf_wr_addr = 9'd100; buf_wr_data = 8'hAA;
    @(negedge clk);
    buf_wr_valid = 1'b0;
    wait_done(400, cyc);
    repeat (3) @(negedge clk);
    chk(inv_hi - i0 == 1, "R11", "busy start flagged", inv_hi - i0, 1);
    chk(done_hi - d0 == 1 && got.size() == 4, "R11", "job unaffected", got.size(), 4);
    for (int k = 0; k < got.size(); k++)
      chk(got[k] == txb(k, 50), "R11", "job bytes", got[k], txb(k, 50));
    chk(prof_o == 4'd1, "R11", "profile kept", prof_o, 1);
    rd(100, v);
    chk(v == 8'h11, "R2", "busy write dropped", v, 8'h11);

    // R12 armed start
    for (int k = 0; k < 2; k++) host_wr(2 + k, txb(k, 90));
    set_hdr(2, 1'b0, 2);
    prep(1'b0, 4, 2'b01, 90);
    r0 = n_rise; d0 = done_hi;
    cmd(2, 8, 4);
    repeat (30) @(negedge clk);
    chk(n_rise == r0 && (&ss_n_o) && done_hi == d0, "R12", "idle before trigger", n_rise - r0, 0);
    trig_i = 1'b1;
    @(negedge clk);
    trig_i = 1'b0;
    wait_done(200, cyc);
    repeat (2) @(negedge clk);
    chk(got.size() == 2 && got[0] == txb(0, 90), "R12", "after trigger",
        got.size() > 0 ? got[0] : 0, txb(0, 90));

    // R13 halt and flush
    for (int k = 0; k < 4; k++) host_wr(2 + k, txb(k, 5));
    set_hdr(2, 1'b0, 4);
    prep(1'b0, 0, 2'b01, 5);
    d0 = done_hi;
    cmd(1, 0, 0);
    repeat (40) @(negedge clk);
    cmd(3, 0, 0);
    r0 = n_rise;
    chk((&ss_n_o) && !sclk_o, "R13", "halt releases", {sclk_o, ss_n_o}, 9'h0FF);
    repeat (200) @(negedge clk);
    chk(done_hi == d0 && n_rise == r0, "R13", "halt no done", done_hi - d0, 0);
    set_hdr(2, 1'b0, 3);
    cmd(1, 0, 0);
    repeat (40) @(negedge clk);
    cmd(4, 0, 0);
    repeat (100) @(negedge clk);
    chk(done_hi == d0 && (&ss_n_o), "R13", "flush no done", done_hi - d0, 0);
    rd(0, v);
    chk(v == 8'h00, "R13", "flush header low", v, 0);
    rd(1, v);
    chk(v == 8'h00, "R13", "flush header high", v, 0);

    // R6 full-buffer read
    run_xfer(3, 1'b0, 512, 5, 4, 77, "R6");
    rd(511, v);
    chk(v == sbytes[511], "R6", "last byte", v, sbytes[511]);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule